// File: doc/BRIEF.md
# Multi-channel ADC scan sequencer

This block is the digital controller that sits in front of an eight-input successive-approximation converter. A scan can be started in three ways: by writing the start bit of the control register, by a timer trigger pulse, or by an external trigger pulse. Once started, the sequencer steps through a group of channels. For each channel it drives a channel number and a one-cycle convert strobe to the converter. It then waits for the converter's done pulse and stores the returned 10-bit result in that channel's own result register.

The channel group is set by a two-bit mode code and a four-bit channel-select field. A scan runs either once, after which the start bit clears itself, or continuously until software clears the start bit. Clearing the start bit in the middle of a continuous scan abandons the conversion in flight, and its result is never stored. The end of every pass sets a sticky completion flag. An interrupt output follows that flag, gated by an enable bit. Software reaches everything through a simple port: address, write enable, write data, read enable and read data.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the control word reads 0, every result register reads 0, irq is 0 and no convert strobe is issued.
- R2: While no scan is running, any of the following starts a scan on the first channel of the selected group: a control write with bit 0 set, a timerTrig pulse, or an extTrig pulse.
- R3: The mode code sits in control bits [5:4] and the channel-select field in bits [9:6]. A mode code with bit 5 clear converts only the single channel numbered by select bits [8:6].
- R4: Mode code 2'b10 selects a four-channel group. Its first channel is 0 when select bit 8 is 0 and 4 when select bit 8 is 1. It scans select bits [7:6] plus one channels upward from there. Select bit 9 is ignored.
- R5: Mode code 2'b11 always starts at channel 0 and scans select bits [8:6] plus one channels. Select bit 9 is ignored.
- R6: Each returned result is stored in the result register of the channel being converted. Addresses 0 to 7 read result registers 0 to 7, zero-extended. Address 8 reads the control word. Registers of channels outside the scan keep their values.
- R7: After the last channel of a pass, the completion flag (control bit 1) becomes 1. irq equals the flag ANDed with the interrupt enable (control bit 2).
- R8: In single-pass mode (control bit 3 = 0), the start bit (control bit 0) reads 0 after the pass, and no further convert strobe follows.
- R9: In continuous mode (control bit 3 = 1), the scan starts again at the group's first channel after each pass, and the flag is set at the end of each pass.
- R10: Writing 0 to the start bit during a conversion ends the scan. The result of that conversion is dropped and no further convert strobe is issued.
- R11: Writing 0 to the completion flag clears it only if a read of address 8 with rdEn has returned the flag as 1 beforehand. Writing 1 never sets the flag.
- R12: Start writes and trigger pulses that arrive while a scan is running do not add strobes or start another scan.
- R13: convStart is a single-cycle pulse, issued exactly once for each channel converted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 4 | Register address for reads and writes |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 16 | Register write data |
| rdEn | input | 1 | Read strobe; arms the flag clear |
| rdData | output | 16 | Read data for regAddr |
| timerTrig | input | 1 | Timer start pulse |
| extTrig | input | 1 | External start pulse |
| convStart | output | 1 | Convert strobe to the converter |
| convChan | output | 3 | Channel to convert |
| convDone | input | 1 | Converter done pulse |
| convResult | input | 10 | Converter result, valid with convDone |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest case to reach from the ports is a stop that lands while a conversion is outstanding in a continuous scan, followed by the converter's late done pulse. The converter model in the bench lets a continuous three-channel scan run for more than two passes. It then switches to a long latency, waits for the next convert strobe, and clears the start bit while that conversion is still pending. When the done pulse arrives afterwards, every result register must still hold its earlier value and no strobe may follow. Random single passes over all mode codes, select values, start sources and converter latencies cover the group decoding.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  // Strobes from the scan control to the register datapath
  typedef struct packed {
    logic writeRes;  // store convResult into the register of convChan
    logic setDone;   // last channel of a pass finished
    logic clrStart;  // single pass ended, drop the start bit
  } scanStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } scanState_t;

  // Control word field positions
  localparam int CB_START = 0;
  localparam int CB_DONE  = 1;
  localparam int CB_IE    = 2;
  localparam int CB_CONT  = 3;
  localparam int CB_MODE  = 4;
  localparam int CB_SEL   = 6;

endpackage

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W = $clog2(NUM_CH),
  localparam int SEL_W = CH_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startBit,
  input  logic [1:0]       cfgMode,
  input  logic [SEL_W-1:0] cfgSel,
  input  logic             cfgCont,
  input  logic             convDone,
  output logic             convStart,
  output logic [CH_W-1:0]  convChan,
  output logic             busy,
  output scanStrobe_t      strobe
);

  localparam logic [CH_W-1:0] ONE_CH = 1;

  scanState_t      state;
  logic [CH_W-1:0] chan, firstChan, lastChan, grpFirst, grpLast;
  logic            contMode;
  logic            unusedSelTop;

  assign unusedSelTop = cfgSel[SEL_W-1];
  assign convChan  = chan;
  assign busy      = (state != ST_IDLE);
  assign convStart = (state == ST_ISSUE) && startBit;

  // Group decode from mode code and channel-select field
  always_comb begin
    case (cfgMode)
      2'b10: begin
        grpFirst = {cfgSel[CH_W-1], {(CH_W-1){1'b0}}};
        grpLast  = grpFirst | {1'b0, cfgSel[CH_W-2:0]};
      end
      2'b11: begin
        grpFirst = '0;
        grpLast  = cfgSel[CH_W-1:0];
      end
      default: begin
        grpFirst = cfgSel[CH_W-1:0];
        grpLast  = cfgSel[CH_W-1:0];
      end
    endcase
  end

  always_comb begin
    strobe = '0;
    if (state == ST_WAIT && startBit && convDone) begin
      strobe.writeRes = 1'b1;
      if (chan == lastChan) begin
        strobe.setDone  = 1'b1;
        strobe.clrStart = !contMode;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      chan      <= '0;
      firstChan <= '0;
      lastChan  <= '0;
      contMode  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (startBit) begin
          firstChan <= grpFirst;
          lastChan  <= grpLast;
          contMode  <= cfgCont;
          chan      <= grpFirst;
          state     <= ST_ISSUE;
        end
        ST_ISSUE: state <= startBit ? ST_WAIT : ST_IDLE;
        ST_WAIT: begin
          if (!startBit) begin
            state <= ST_IDLE;
          end else if (convDone) begin
            if (chan == lastChan) begin
              if (contMode) begin
                chan  <= firstChan;
                state <= ST_ISSUE;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              chan  <= chan + ONE_CH;
              state <= ST_ISSUE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R13: the convert strobe never lasts two cycles
  assert_strobe_pulse_R13: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  // R3: every strobed channel lies inside the latched group
  assert_chan_in_group_R3: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> (chan >= firstChan && chan <= lastChan));

  // R10: a cleared start bit ends any scan on the next edge
  assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !startBit) |=> !busy);

endmodule

// File: rtl/adc_scan_regs.sv
module adc_scan_regs
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 10,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  localparam int CH_W = $clog2(NUM_CH),
  localparam int SEL_W = CH_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic              timerTrig,
  input  logic              extTrig,
  input  logic              busy,
  input  scanStrobe_t       strobe,
  input  logic [CH_W-1:0]   convChan,
  input  logic [RES_W-1:0]  convResult,
  output logic              startBit,
  output logic [1:0]        cfgMode,
  output logic [SEL_W-1:0]  cfgSel,
  output logic              cfgCont,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_CH);
  localparam int CTRL_USED = CB_SEL + SEL_W;

  logic             doneFlag, intEn, clrArmed;
  logic             wrCtrl, rdCtrl, clrOk;
  logic [RES_W-1:0] resReg [NUM_CH];
  logic [DATA_W-1:0] ctrlWord;
  logic             unusedWrTop;

  assign unusedWrTop = ^wrData[DATA_W-1:CTRL_USED];
  assign wrCtrl = wrEn && (regAddr == CTRL_ADDR);
  assign rdCtrl = rdEn && (regAddr == CTRL_ADDR);
  assign clrOk  = wrCtrl && !wrData[CB_DONE] && clrArmed;
  assign irq    = doneFlag && intEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startBit <= 1'b0;
      intEn    <= 1'b0;
      cfgCont  <= 1'b0;
      cfgMode  <= '0;
      cfgSel   <= '0;
    end else begin
      if (wrCtrl) begin
        intEn   <= wrData[CB_IE];
        cfgCont <= wrData[CB_CONT];
        cfgMode <= wrData[CB_MODE +: 2];
        cfgSel  <= wrData[CB_SEL +: SEL_W];
      end
      if (strobe.clrStart)
        startBit <= 1'b0;
      else if (wrCtrl)
        startBit <= wrData[CB_START];
      else if ((timerTrig || extTrig) && !busy && !startBit)
        startBit <= 1'b1;
    end
  end

  // Sticky completion flag with read-then-clear protocol
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag <= 1'b0;
      clrArmed <= 1'b0;
    end else begin
      if (strobe.setDone) doneFlag <= 1'b1;
      else if (clrOk)     doneFlag <= 1'b0;
      if (clrOk)                    clrArmed <= 1'b0;
      else if (rdCtrl && doneFlag)  clrArmed <= 1'b1;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_res
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        resReg[ch] <= '0;
      else if (strobe.writeRes && convChan == CH_W'(ch))
        resReg[ch] <= convResult;
    end
  end

  assign ctrlWord = {{(DATA_W-CTRL_USED){1'b0}}, cfgSel, cfgMode, cfgCont,
                     intEn, doneFlag, startBit};

  always_comb begin
    if (regAddr < CTRL_ADDR)
      rdData = {{(DATA_W-RES_W){1'b0}}, resReg[regAddr[CH_W-1:0]]};
    else if (regAddr == CTRL_ADDR)
      rdData = ctrlWord;
    else
      rdData = '0;
  end

  // R8: a finished single pass leaves the start bit low
  assert_single_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrStart |=> !startBit);

  // R7: end of pass raises the completion flag
  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setDone |=> doneFlag);

  // R10: no result is stored once the start bit is low
  assert_no_store_stopped_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeRes |-> startBit);

  // R11: the flag only falls on a control write
  assert_flag_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !wrCtrl) |=> doneFlag);

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 10,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic              timerTrig,
  input  logic              extTrig,
  output logic              convStart,
  output logic [CH_W-1:0]   convChan,
  input  logic              convDone,
  input  logic [RES_W-1:0]  convResult,
  output logic              irq
);

  scanStrobe_t   strobe;
  logic          startBit, busy, cfgCont;
  logic [1:0]    cfgMode;
  logic [CH_W:0] cfgSel;

  adc_scan_regs #(
    .NUM_CH(NUM_CH), .RES_W(RES_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk, .rstN, .regAddr, .wrEn, .wrData, .rdEn, .rdData,
    .timerTrig, .extTrig, .busy, .strobe, .convChan, .convResult,
    .startBit, .cfgMode, .cfgSel, .cfgCont, .irq
  );

  adc_scan_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk, .rstN, .startBit, .cfgMode, .cfgSel, .cfgCont, .convDone,
    .convStart, .convChan, .busy, .strobe
  );

endmodule

// File: tb/adc_scan_seq_tb.sv
module adc_scan_seq_tb;

  logic        clk = 1'b0, rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        timerTrig = 1'b0, extTrig = 1'b0;
  logic        convStart, irq;
  logic [2:0]  convChan;
  logic        convDone = 1'b0;
  logic [9:0]  convResult = '0;

  int total = 0, bad = 0;
  int logN = 0, doubleCnt = 0;
  int logCh [64];
  int expRes [8];
  int convLat = 1, cntdown = 0, pendCh = 0, pendVal = 0;
  bit acceptDones = 1'b1, prevStart = 1'b0;

  adc_scan_seq u_dut (
    .clk, .rstN, .regAddr, .wrEn, .wrData, .rdEn, .rdData,
    .timerTrig, .extTrig, .convStart, .convChan, .convDone, .convResult, .irq
  );

  always #5 clk = ~clk;

  // Converter model and strobe monitor, away from the active edge
  always @(negedge clk) begin
    if (convDone) convDone = 1'b0;
    if (cntdown > 0) begin
      cntdown--;
      if (cntdown == 0) begin
        convDone = 1'b1;
        convResult = pendVal[9:0];
        if (acceptDones) expRes[pendCh] = pendVal;
      end
    end
    if (convStart && prevStart) doubleCnt++;
    prevStart = convStart;
    if (convStart) begin
      if (logN < 64) logCh[logN] = int'(convChan);
      logN++;
      pendCh = int'(convChan);
      pendVal = int'($urandom % 1024);
      if (pendVal == expRes[pendCh]) pendVal = pendVal ^ 1;
      cntdown = convLat;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int grpFirst(input int mode, input int sel);
    if (mode == 2) return (sel & 4);
    if (mode == 3) return 0;
    return sel & 7;
  endfunction

  function automatic int grpCount(input int mode, input int sel);
    if (mode == 2) return (sel & 3) + 1;
    if (mode == 3) return (sel & 7) + 1;
    return 1;
  endfunction

  function automatic logic [15:0] ctrlWord(input int st, input int dn, input int ie,
                                           input int cont, input int mode, input int sel);
    return 16'((sel << 6) | (mode << 4) | (cont << 3) | (ie << 2) | (dn << 1) | st);
  endfunction

  function automatic string grpTag(input int mode);
    if (mode == 2) return "R4";
    if (mode == 3) return "R5";
    return "R3";
  endfunction

  task automatic wrReg(input int addr, input logic [15:0] data);
    @(negedge clk); #1;
    regAddr = 4'(addr); wrData = data; wrEn = 1'b1;
    @(negedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic peek(input int addr, output int val);
    @(negedge clk); #1;
    regAddr = 4'(addr);
    #1 val = int'(rdData);
  endtask

  task automatic readArm(output int val);
    @(negedge clk); #1;
    regAddr = 4'd8; rdEn = 1'b1;
    #1 val = int'(rdData);
    @(negedge clk); #1;
    rdEn = 1'b0;
  endtask

  task automatic pulseTrig(input int how);
    @(negedge clk); #1;
    if (how == 1) timerTrig = 1'b1; else extTrig = 1'b1;
    @(negedge clk); #1;
    timerTrig = 1'b0; extTrig = 1'b0;
  endtask

  task automatic waitFlag(output bit seen);
    int v;
    seen = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      peek(8, v);
      if (v & 2) begin seen = 1'b1; break; end
    end
  endtask

  task automatic waitLog(input int n);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); #1;
      if (logN >= n) break;
    end
  endtask

  task automatic checkResults(input string tag);
    int v;
    for (int ch = 0; ch < 8; ch++) begin
      peek(ch, v);
      check(v == expRes[ch], tag, v, expRes[ch]);
    end
  endtask

  task automatic runScan(input int mode, input int sel, input int ie, input int how,
                         input int lat, input bit trigTest, input bit flagTest);
    int v, cnt, first;
    bit seen;
    cnt = grpCount(mode, sel);
    first = grpFirst(mode, sel);
    logN = 0; convLat = lat; acceptDones = 1'b1;
    if (how == 0) wrReg(8, ctrlWord(1, 0, ie, 0, mode, sel));
    else begin
      wrReg(8, ctrlWord(0, 0, ie, 0, mode, sel));
      pulseTrig(how);
    end
    if (trigTest) begin
      waitLog(1);
      pulseTrig(1);
      pulseTrig(2);
      wrReg(8, ctrlWord(1, 0, ie, 0, mode, sel));
    end
    waitFlag(seen);
    check(seen, "R7 flag after pass", int'(seen), 1);
    repeat (2) @(negedge clk);
    check(logN == cnt, grpTag(mode), logN, cnt);
    check(logCh[0] == first, "R2 first channel", logCh[0], first);
    for (int i = 0; i < cnt && i < 64; i++)
      check(logCh[i] == first + i, grpTag(mode), logCh[i], first + i);
    peek(8, v);
    check((v & 1) == 0, "R8 start bit cleared", v & 1, 0);
    check(irq == ie[0], "R7 irq", int'(irq), ie);
    checkResults("R6 result registers");
    repeat (12) @(negedge clk);
    check(logN == cnt, trigTest ? "R12 no extra strobes" : "R8 no further strobes", logN, cnt);
    if (flagTest) begin
      wrReg(8, ctrlWord(0, 0, ie, 0, mode, sel));
      peek(8, v);
      check((v & 2) != 0, "R11 clear without read", (v >> 1) & 1, 1);
    end
    readArm(v);
    wrReg(8, ctrlWord(0, 0, ie, 0, mode, sel));
    peek(8, v);
    check((v & 2) == 0, "R11 clear after read", (v >> 1) & 1, 0);
    check(irq == 1'b0, "R7 irq low after clear", int'(irq), 0);
    if (flagTest) begin
      wrReg(8, ctrlWord(0, 1, ie, 0, mode, sel));
      peek(8, v);
      check((v & 2) == 0, "R11 write 1 does not set", (v >> 1) & 1, 0);
    end
  endtask

  initial begin
    int v, stopAt;
    bit seen;
    void'($urandom(32'd4242));
    for (int ch = 0; ch < 8; ch++) expRes[ch] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    peek(8, v);
    check(v == 0, "R1 control word", v, 0);
    check(irq == 1'b0, "R1 irq", int'(irq), 0);
    check(convStart == 1'b0, "R1 no strobe", int'(convStart), 0);
    checkResults("R1 results zero");

    // Directed corner cases
    runScan(3, 7, 1, 0, 2, 1'b0, 1'b1);   // eight channels from 0
    runScan(2, 7, 1, 1, 3, 1'b0, 1'b0);   // four channels from 4
    runScan(2, 9, 0, 2, 1, 1'b0, 1'b0);   // top select bit ignored
    runScan(1, 5, 1, 0, 8, 1'b1, 1'b0);   // single channel, triggers while busy
    runScan(3, 3, 1, 2, 8, 1'b1, 1'b0);   // R12 on a longer scan

    // Random single passes
    for (int i = 0; i < 24; i++)
      runScan(int'($urandom % 4), int'($urandom % 16), int'($urandom % 2),
              i % 3, 1 + int'($urandom % 6), 1'b0, 1'b0);

    // R9 continuous scan, channels 0..2
    logN = 0; convLat = 3; acceptDones = 1'b1;
    wrReg(8, ctrlWord(1, 0, 1, 1, 3, 2));
    waitLog(7);
    for (int i = 0; i < 7; i++)
      check(logCh[i] == i % 3, "R9 restart order", logCh[i], i % 3);
    peek(8, v);
    check((v & 2) != 0, "R9 flag each pass", (v >> 1) & 1, 1);
    check((v & 1) != 0, "R9 start bit held", v & 1, 1);

    // R10 stop while a conversion is outstanding
    convLat = 25;
    waitLog(8);
    acceptDones = 1'b0;
    stopAt = logN;
    wrReg(8, ctrlWord(0, 0, 1, 1, 3, 2));
    repeat (60) @(negedge clk);
    check(logN == stopAt, "R10 no strobe after stop", logN, stopAt);
    peek(8, v);
    check((v & 1) == 0, "R10 start bit low", v & 1, 0);
    checkResults("R10 discarded result");
    readArm(v);
    wrReg(8, ctrlWord(0, 0, 0, 0, 3, 2));

    check(doubleCnt == 0, "R13 single-cycle strobe", doubleCnt, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule